// File: doc/BRIEF.md
# Prioritised Bus Interrupter with Daisy-Chained Acknowledge

This block raises interrupts on a backplane bus on behalf of four 8-bit input banks, called groups A to D. Every clock it compares each bank with the value that bank had one cycle earlier. Any difference marks the group pending, provided that group is enabled. While the global enable is set and a non-zero level is programmed, the block pulls down one of seven active-low request lines, chosen by that level. All four groups share this single line. When more than one group is waiting, the block serves them in fixed order, A first and D last.

The interrupt handler starts an acknowledge cycle by pulling the daisy-chained acknowledge input low and placing a 3-bit level code on its address lines. The block claims the cycle only when three things hold: the code equals the programmed level, the block is requesting, and the cycle has just begun. When it claims, it blocks the chain, returns the vector of the group being served with a one-cycle strobe, clears that group's pending flag and clears the global enable. Otherwise the acknowledge passes straight to the next board in the chain. Groups that were not served stay pending, so they request again once software sets the enable.

Software reaches the configuration through a small register port with one-cycle read latency. A control word sits at offset 0x400 and there is one vector register per group.

Top module: `irq_requester`

## Requirements
- R1: After reset all request lines are high (7'h7F), the vector strobe is low, the acknowledge output follows the acknowledge input, and the control word and all vector registers read 0.
- R2: The control word at offset 0x400 holds the global enable in bit 1, the level in bits 4:2 and the group A..D enables in bits 11:8. Vector registers for groups A..D sit at 0x020, 0x120, 0x220 and 0x320, in bits 7:0. Reads return data one cycle after the address is presented. Reserved bits and unmapped addresses read 0.
- R3: A change in any bit of a bank whose group enable is set makes that group pending in the same clock. A change on a disabled bank is ignored, and enabling that group later does not raise a request.
- R4: While enabled with level L from 1 to 7 and any enabled group pending, request line bit L-1 is low and all other lines are high. Level 000 drives no line, and at no time is more than one line low.
- R5: Pending groups are served in fixed order A, B, C, D. Each claimed acknowledge delivers the vector of the highest-priority enabled pending group.
- R6: An acknowledge cycle is claimed when the input falls, the acknowledged level equals the programmed level, and the block is requesting. The acknowledge output then stays high for the whole cycle. On the next clock the vector appears with the strobe high for exactly one cycle.
- R7: A claimed acknowledge clears the global enable, which takes priority over a same-cycle write, and clears only the served group's pending flag. After that all request lines are high until software sets the enable again, and then the remaining pending groups request in order.
- R8: An acknowledge with a non-matching level, or one arriving while the block is not requesting, is passed to the acknowledge output. In that case the strobe stays low, the request stays as it was and the enable bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_in | input | 32 | Four 8-bit input banks, group A in bits 7:0 up to group D in bits 31:24 |
| reg_addr | input | 12 | Register address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, one cycle after the address |
| iack_in_n | input | 1 | Acknowledge from upstream in the chain, active low |
| ack_level | input | 3 | Level being acknowledged (address lines 3:1) |
| iack_out_n | output | 1 | Acknowledge passed to downstream, active low |
| irq_n | output | 7 | Request lines 1 to 7, active low |
| vec_out | output | 8 | Vector returned for a claimed acknowledge |
| vec_valid | output | 1 | One-cycle strobe qualifying vec_out |

## Verification
On every cycle the assertions check four properties at the ports. At most one request line is low. The vector strobe never lasts beyond one cycle. A delivered vector coincides with all request lines released and the chain blocked. A high acknowledge input always reaches the output. The bench scenarios show the remaining behaviour: the register map and its reserved bits, the A-to-D service order across successive re-arms, the fact that a disabled bank is ignored, level 000 suppressing the request, and forwarding of a mismatched acknowledge without touching the enable bit.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int CSR_OFS    = 'h400;
  localparam int VEC_BASE   = 'h020;
  localparam int VEC_STRIDE = 'h100;
  localparam int EN_BIT     = 1;
  localparam int LVL_LSB    = 2;
  localparam int GEN_LSB    = 8;
endpackage

// File: rtl/irq_cos_detect.sv
module irq_cos_detect #(
  parameter int NGROUPS = 4,
  parameter int BANK_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NGROUPS*BANK_W-1:0] bank_in,
  output logic [NGROUPS-1:0]        cos
);
  logic [NGROUPS*BANK_W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= bank_in;
  end

  for (genvar g = 0; g < NGROUPS; g++) begin : g_bank
    assign cos[g] = |(bank_in[g*BANK_W +: BANK_W] ^ prev_q[g*BANK_W +: BANK_W]);
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int NGROUPS = 4,
  parameter int VEC_W   = 8,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 16,
  parameter int LVL_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic                     reg_we,
  input  logic [DATA_W-1:0]        reg_wdata,
  output logic [DATA_W-1:0]        reg_rdata,
  input  logic                     en_clr,
  output logic                     en,
  output logic [LVL_W-1:0]         lvl,
  output logic [NGROUPS-1:0]       gen,
  output logic [NGROUPS*VEC_W-1:0] vec_flat
);
  logic                csr_hit;
  logic [NGROUPS-1:0]  vec_hit;
  logic                en_d;
  logic [LVL_W-1:0]    lvl_d;
  logic [NGROUPS-1:0]  gen_d;
  logic [DATA_W-1:0]   rd_d;

  assign csr_hit = (reg_addr == ADDR_W'(CSR_OFS));

  for (genvar g = 0; g < NGROUPS; g++) begin : g_vec
    assign vec_hit[g] = (reg_addr == ADDR_W'(VEC_BASE + g * VEC_STRIDE));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        vec_flat[g*VEC_W +: VEC_W] <= '0;
      else if (reg_we && vec_hit[g])
        vec_flat[g*VEC_W +: VEC_W] <= reg_wdata[VEC_W-1:0];
    end
  end

  always_comb begin
    en_d  = en;
    lvl_d = lvl;
    gen_d = gen;
    if (reg_we && csr_hit) begin
      en_d  = reg_wdata[EN_BIT];
      lvl_d = reg_wdata[LVL_LSB +: LVL_W];
      gen_d = reg_wdata[GEN_LSB +: NGROUPS];
    end
    if (en_clr) en_d = 1'b0;
  end

  always_comb begin
    rd_d = '0;
    if (csr_hit) begin
      rd_d[EN_BIT]             = en;
      rd_d[LVL_LSB +: LVL_W]   = lvl;
      rd_d[GEN_LSB +: NGROUPS] = gen;
    end
    for (int g = 0; g < NGROUPS; g++)
      if (vec_hit[g]) rd_d[VEC_W-1:0] = vec_flat[g*VEC_W +: VEC_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en        <= 1'b0;
      lvl       <= '0;
      gen       <= '0;
      reg_rdata <= '0;
    end else begin
      en        <= en_d;
      lvl       <= lvl_d;
      gen       <= gen_d;
      reg_rdata <= rd_d;
    end
  end
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl #(
  parameter int NGROUPS = 4,
  parameter int VEC_W   = 8,
  parameter int LVL_W   = 3,
  localparam int NLINES = (1 << LVL_W) - 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NGROUPS-1:0]       cos,
  input  logic                     en,
  input  logic [LVL_W-1:0]         lvl,
  input  logic [NGROUPS-1:0]       gen,
  input  logic [NGROUPS*VEC_W-1:0] vec_flat,
  input  logic                     iack_in_n,
  input  logic [LVL_W-1:0]         ack_level,
  output logic [NLINES-1:0]        irq_n,
  output logic                     iack_out_n,
  output logic [VEC_W-1:0]         vec_out,
  output logic                     vec_valid,
  output logic                     en_clr
);
  logic [NGROUPS-1:0] pend_q, pend_d, active, grant;
  logic               found, requesting, ack_start, match;
  logic               iack_prev_q, claim_q, claim_d;
  logic [VEC_W-1:0]   sel_vec;

  assign active = pend_q & gen;

  always_comb begin
    grant   = '0;
    found   = 1'b0;
    sel_vec = '0;
    for (int g = 0; g < NGROUPS; g++) begin
      if (active[g] && !found) begin
        grant[g] = 1'b1;
        found    = 1'b1;
        sel_vec  = vec_flat[g*VEC_W +: VEC_W];
      end
    end
  end

  assign requesting = en && (lvl != '0) && (|active);

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    assign irq_n[i] = !(requesting && (lvl == LVL_W'(i + 1)));
  end

  assign ack_start  = !iack_in_n && iack_prev_q;
  assign match      = ack_start && requesting && (ack_level == lvl);
  assign claim_d    = iack_in_n ? 1'b0 : (claim_q || match);
  assign iack_out_n = iack_in_n || match || claim_q;
  assign en_clr     = match;
  assign pend_d     = (pend_q & ~(match ? grant : '0)) | (cos & gen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= '0;
      iack_prev_q <= 1'b1;
      claim_q     <= 1'b0;
      vec_valid   <= 1'b0;
    end else begin
      pend_q      <= pend_d;
      iack_prev_q <= iack_in_n;
      claim_q     <= claim_d;
      vec_valid   <= match;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vec_out <= '0;
    else if (match) vec_out <= sel_vec;
  end
endmodule

// File: rtl/irq_requester.sv
module irq_requester #(
  parameter int NGROUPS = 4,
  parameter int BANK_W  = 8,
  parameter int VEC_W   = 8,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 16,
  parameter int LVL_W   = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NGROUPS*BANK_W-1:0]   bank_in,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic                        reg_we,
  input  logic [DATA_W-1:0]           reg_wdata,
  output logic [DATA_W-1:0]           reg_rdata,
  input  logic                        iack_in_n,
  input  logic [LVL_W-1:0]            ack_level,
  output logic                        iack_out_n,
  output logic [(1<<LVL_W)-2:0]       irq_n,
  output logic [VEC_W-1:0]            vec_out,
  output logic                        vec_valid
);
  logic [1:0]               rst_sync_q;
  logic                     rst_sync_n;
  logic [NGROUPS-1:0]       cos, gen;
  logic                     en, en_clr;
  logic [LVL_W-1:0]         lvl;
  logic [NGROUPS*VEC_W-1:0] vec_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  irq_cos_detect #(.NGROUPS(NGROUPS), .BANK_W(BANK_W)) u_cos (
    .clk(clk), .rst_n(rst_sync_n), .bank_in(bank_in), .cos(cos)
  );

  irq_regs #(.NGROUPS(NGROUPS), .VEC_W(VEC_W), .ADDR_W(ADDR_W),
             .DATA_W(DATA_W), .LVL_W(LVL_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .en_clr(en_clr),
    .en(en), .lvl(lvl), .gen(gen), .vec_flat(vec_flat)
  );

  irq_ack_ctrl #(.NGROUPS(NGROUPS), .VEC_W(VEC_W), .LVL_W(LVL_W)) u_ack (
    .clk(clk), .rst_n(rst_sync_n), .cos(cos), .en(en), .lvl(lvl), .gen(gen),
    .vec_flat(vec_flat), .iack_in_n(iack_in_n), .ack_level(ack_level),
    .irq_n(irq_n), .iack_out_n(iack_out_n), .vec_out(vec_out),
    .vec_valid(vec_valid), .en_clr(en_clr)
  );
endmodule

// File: rtl/irq_requester_chk.sv
module irq_requester_chk #(
  parameter int NLINES = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NLINES-1:0] irq_n,
  input logic              iack_in_n,
  input logic              iack_out_n,
  input logic              vec_valid
);
  a_r4_one_line_low: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~irq_n));

  a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);

  a_r7_released_on_vector: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (&irq_n));

  a_r6_chain_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> iack_out_n);

  a_r8_idle_passes: assert property (@(posedge clk) disable iff (!rst_n)
    iack_in_n |-> iack_out_n);
endmodule

bind irq_requester irq_requester_chk #(.NLINES((1 << LVL_W) - 1)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .irq_n(irq_n), .iack_in_n(iack_in_n),
  .iack_out_n(iack_out_n), .vec_valid(vec_valid)
);

// File: tb/irq_requester_test.sv
module irq_requester_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] bank_in;
  logic [11:0] reg_addr;
  logic        reg_we;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        iack_in_n;
  logic [2:0]  ack_level;
  logic        iack_out_n;
  logic [6:0]  irq_n;
  logic [7:0]  vec_out;
  logic        vec_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  irq_requester uut (
    .clk(clk), .rst_n(rst_n), .bank_in(bank_in), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .iack_in_n(iack_in_n), .ack_level(ack_level), .iack_out_n(iack_out_n),
    .irq_n(irq_n), .vec_out(vec_out), .vec_valid(vec_valid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic toggle_bank(input logic [31:0] mask);
    @(negedge clk);
    bank_in = bank_in ^ mask;
    @(negedge clk);
  endtask

  task automatic ack_match(input logic [2:0] lv, input logic [7:0] exp_vec, input string tag);
    @(negedge clk);
    ack_level = lv; iack_in_n = 1'b0;
    #1 check({tag, " chain blocked"}, iack_out_n, 1'b1);
    @(negedge clk);
    check({tag, " strobe"}, vec_valid, 1'b1);
    check({tag, " vector"}, vec_out, exp_vec);
    check({tag, " lines released"}, irq_n, 7'h7F);
    @(negedge clk);
    check({tag, " strobe one cycle"}, vec_valid, 1'b0);
    iack_in_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    check("R1 irq lines", irq_n, 7'h7F);
    check("R1 strobe", vec_valid, 1'b0);
    check("R1 chain follows", iack_out_n, 1'b1);
    rd(12'h400, d); check("R1 control word", d, 16'h0000);
    rd(12'h320, d); check("R1 vector D", d, 16'h0000);
  endtask

  task automatic t_regs;
    logic [15:0] d;
    wr(12'h020, 16'hFFA1);
    wr(12'h120, 16'h00B2);
    wr(12'h220, 16'h00C3);
    wr(12'h320, 16'h00D4);
    rd(12'h020, d); check("R2 vector A reserved zero", d, 16'h00A1);
    rd(12'h220, d); check("R2 vector C", d, 16'h00C3);
    wr(12'h400, 16'h0F0F);
    rd(12'h400, d); check("R2 control word", d, 16'h0F0E);
    rd(12'h024, d); check("R2 unmapped", d, 16'h0000);
    check("R3 no change no request", irq_n, 7'h7F);
  endtask

  task automatic t_mismatch;
    logic [15:0] d;
    toggle_bank(32'h0001_0000);
    check("R3 R4 group C on level 3", irq_n, 7'h7B);
    @(negedge clk);
    ack_level = 3'd5; iack_in_n = 1'b0;
    #1 check("R8 forwarded", iack_out_n, 1'b0);
    @(negedge clk);
    check("R8 no strobe", vec_valid, 1'b0);
    check("R8 request held", irq_n, 7'h7B);
    iack_in_n = 1'b1;
    @(negedge clk);
    rd(12'h400, d); check("R8 enable kept", d, 16'h0F0E);
  endtask

  task automatic t_priority;
    logic [15:0] d;
    toggle_bank(32'hFF00_00FF);
    check("R4 still one line", irq_n, 7'h7B);
    ack_match(3'd3, 8'hA1, "R5 R6 first A");
    rd(12'h400, d); check("R7 enable cleared", d, 16'h0F0C);
    wr(12'h400, 16'h0F0E);
    check("R7 rearm requests", irq_n, 7'h7B);
    ack_match(3'd3, 8'hC3, "R5 then C");
    wr(12'h400, 16'h0F0E);
    ack_match(3'd3, 8'hD4, "R5 then D");
    wr(12'h400, 16'h0F0E);
    check("R7 nothing left", irq_n, 7'h7F);
  endtask

  task automatic t_level;
    wr(12'h400, 16'h0F02);
    toggle_bank(32'h0000_FF00);
    check("R4 level zero silent", irq_n, 7'h7F);
    wr(12'h400, 16'h0F1E);
    check("R4 level 7", irq_n, 7'h3F);
    ack_match(3'd7, 8'hB2, "R6 level 7 B");
  endtask

  task automatic t_disabled;
    wr(12'h400, 16'h010E);
    toggle_bank(32'hFF00_0000);
    check("R3 disabled bank ignored", irq_n, 7'h7F);
    wr(12'h400, 16'h080E);
    check("R3 later enable no request", irq_n, 7'h7F);
    @(negedge clk);
    ack_level = 3'd3; iack_in_n = 1'b0;
    #1 check("R8 idle forwarded", iack_out_n, 1'b0);
    @(negedge clk);
    check("R8 idle no strobe", vec_valid, 1'b0);
    iack_in_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bank_in = 32'h1234_5678; reg_addr = '0; reg_we = 1'b0;
    reg_wdata = '0; iack_in_n = 1'b1; ack_level = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_mismatch();
    t_priority();
    t_level();
    t_disabled();
    finish_run();
  end
endmodule